// File: doc/BRIEF.md
# Paged Address Translation Register File

This block extends the 64 KB logical space of an 8-bit CPU to a 1 MB physical space. The logical space is cut into sixteen 4 KB pages. Each page owns one 8-bit page register. On every bus cycle the top four logical address bits pick a register. The register's value, with its low nibble inverted, becomes physical address bits 19..12. The low twelve logical bits pass straight through. Translation is pure combinational logic, so it adds no cycle to an access.

The CPU reprograms the registers through a write window that covers the top 256 bytes of the logical map. In that window the low four address bits pick the register to write, while the high four bits still pick the register used for translation. Reads in the window return boot ROM data, so from the CPU's side the registers are write-only. Three region flags tell the surrounding decode where a translated access lands: the monitor ROM, the I/O page or the on-chip RAM window.

Top module: `pgx_map_top`

## Requirements
- R1: `bus_addr[15:12]` selects one of sixteen page registers. `phys_addr_o[19:12]` equals `page_o`, and `phys_addr_o[11:0]` equals `bus_addr[11:0]`.
- R2: `page_o[7:4]` equals bits 7..4 of the stored value, and `page_o[3:0]` is the bitwise inverse of stored bits 3..0.
- R3: The register written is chosen by `bus_addr[3:0]`, independently of `bus_addr[15:12]`.
- R4: A write needs all four of these: `bus_cs`=1, `bus_vma`=1, `bus_rw`=0 and `bus_addr[15:8]`=0xFF. If any one is missing, no register changes.
- R5: While `rst_n` is low, every register is cleared to zero, so every page then translates to 0x0F.
- R6: Translation follows the current address in the same cycle. A write becomes visible from the next cycle on, including a write to the page being translated.
- R7: `rom_hit_o` is 1 when `bus_addr[15:8]`=0xFF or when `page_o[3:0]`=0xF.
- R8: `io_hit_o` is 1 exactly when `page_o[3:0]`=0xE and the address is outside the 0xFF window.
- R9: `ram_hit_o` is 1 exactly when `page_o[7:1]`=7'b0000110 (physical 0x0C000–0x0DFFF) and the address is outside the 0xFF window.
- R10: At most one of the three region flags is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select for register writes |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_vma | input | 1 | Bus cycle valid |
| bus_addr | input | 16 | Logical address |
| bus_wdata | input | 8 | Write data |
| page_o | output | 8 | Translated page (inverted low nibble) |
| phys_addr_o | output | 20 | Physical address |
| rom_hit_o | output | 1 | Access lands in monitor ROM |
| io_hit_o | output | 1 | Access lands in the I/O page |
| ram_hit_o | output | 1 | Access lands in the on-chip RAM window |

## Verification
A register write and a translation happen in the same cycle whenever an address in 0xFF00–0xFFFF is written. The hardest case is a write to register 15 from address 0xFF0F: it changes the very page that the same cycle is translating. The bench provokes this with directed writes and with random cycles aimed at the window. In each such cycle it checks that the output still shows the old mapping before the clock edge, and that the following cycle shows the new mapping.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  // physical nibble codes classified by the region logic
  localparam int unsigned CLS_W   = 4;
  localparam logic [CLS_W-1:0] ROM_NIB = 4'hF;
  localparam logic [CLS_W-1:0] IO_NIB  = 4'hE;

  typedef struct packed {
    logic rom;
    logic io;
    logic ram;
  } region_t;
endpackage

// File: rtl/pgx_wr_dec.sv
module pgx_wr_dec #(
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned TAG_W   = 8,
  parameter logic [TAG_W-1:0] WIN_TAG = 8'hFF,
  localparam int unsigned NREG   = 1 << IDX_W
) (
  input  logic             cs,
  input  logic             rw,
  input  logic             vma,
  input  logic [TAG_W-1:0] tag,
  input  logic [IDX_W-1:0] widx,
  output logic             in_win,
  output logic [NREG-1:0]  we
);
  logic wr_cycle;

  always_comb begin
    in_win   = (tag == WIN_TAG);
    wr_cycle = cs & vma & ~rw & in_win;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we[i] = wr_cycle & (widx == IDX_W'(i));
  end
endmodule

// File: rtl/pgx_regfile.sv
module pgx_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned PG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0]           we,
  input  logic [PG_W-1:0]           wdata,
  output logic [NREG-1:0][PG_W-1:0] q
);
  logic [NREG-1:0][PG_W-1:0] d;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_comb begin
      d[i] = q[i];
      if (we[i]) d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PG_W  = 8,
  parameter int unsigned INV_W = 4,
  parameter logic [PG_W-2:0] RAM_TAG = 7'b0000110,
  localparam int unsigned NREG = 1 << IDX_W
) (
  input  logic [NREG-1:0][PG_W-1:0] q,
  input  logic [IDX_W-1:0]          ridx,
  input  logic                      in_win,
  output logic [PG_W-1:0]           page,
  output region_t                   region
);
  localparam logic [PG_W-1:0] INV_MASK = PG_W'((1 << INV_W) - 1);

  always_comb begin
    page       = q[ridx] ^ INV_MASK;
    region.rom = in_win | (page[CLS_W-1:0] == ROM_NIB);
    region.io  = ~in_win & (page[CLS_W-1:0] == IO_NIB);
    region.ram = ~in_win & (page[PG_W-1:1] == RAM_TAG);
  end
endmodule

// File: rtl/pgx_map_top.sv
module pgx_map_top
  import pgx_pkg::*;
#(
  parameter int unsigned LA_W  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PG_W  = 8,
  parameter int unsigned INV_W = 4,
  parameter int unsigned TAG_W = 8,
  parameter logic [TAG_W-1:0] WIN_TAG = 8'hFF,
  localparam int unsigned OFF_W = LA_W - IDX_W,
  localparam int unsigned PA_W  = OFF_W + PG_W,
  localparam int unsigned NREG  = 1 << IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_cs,
  input  logic            bus_rw,
  input  logic            bus_vma,
  input  logic [LA_W-1:0] bus_addr,
  input  logic [PG_W-1:0] bus_wdata,
  output logic [PG_W-1:0] page_o,
  output logic [PA_W-1:0] phys_addr_o,
  output logic            rom_hit_o,
  output logic            io_hit_o,
  output logic            ram_hit_o
);
  logic                      in_win;
  logic [NREG-1:0]           we;
  logic [NREG-1:0][PG_W-1:0] q;
  region_t                   region;

  pgx_wr_dec #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG)) u_dec (
    .cs    (bus_cs),
    .rw    (bus_rw),
    .vma   (bus_vma),
    .tag   (bus_addr[LA_W-1 -: TAG_W]),
    .widx  (bus_addr[IDX_W-1:0]),
    .in_win(in_win),
    .we    (we)
  );

  pgx_regfile #(.NREG(NREG), .PG_W(PG_W)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (we),
    .wdata(bus_wdata),
    .q    (q)
  );

  pgx_xlate #(.IDX_W(IDX_W), .PG_W(PG_W), .INV_W(INV_W)) u_xl (
    .q     (q),
    .ridx  (bus_addr[LA_W-1 -: IDX_W]),
    .in_win(in_win),
    .page  (page_o),
    .region(region)
  );

  always_comb begin
    phys_addr_o = {page_o, bus_addr[OFF_W-1:0]};
    rom_hit_o   = region.rom;
    io_hit_o    = region.io;
    ram_hit_o   = region.ram;
  end
endmodule

// File: rtl/pgx_map_chk.sv
module pgx_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_rw,
  input logic        bus_vma,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  page_o,
  input logic        rom_hit_o,
  input logic        io_hit_o,
  input logic        ram_hit_o
);
  logic wr_port;
  assign wr_port = bus_cs & bus_vma & ~bus_rw & (bus_addr[15:8] == 8'hFF);

  // R6 R3 R2
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> (bus_addr[15:12] != $past(bus_addr[3:0])) ||
                (page_o == {$past(bus_wdata[7:4]), ~$past(bus_wdata[3:0])}));

  // R4
  no_wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_port) |=> (bus_addr[15:12] != $past(bus_addr[15:12])) || $stable(page_o));

  // R7
  win_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[15:8] == 8'hFF) |-> rom_hit_o);

  // R8
  io_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit_o |-> (page_o[3:0] == 4'hE));

  // R9
  ram_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit_o |-> (page_o[7:1] == 7'b0000110));

  // R10
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_hit_o, io_hit_o, ram_hit_o}));
endmodule

bind pgx_map_top pgx_map_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_cs   (bus_cs),
  .bus_rw   (bus_rw),
  .bus_vma  (bus_vma),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .page_o   (page_o),
  .rom_hit_o(rom_hit_o),
  .io_hit_o (io_hit_o),
  .ram_hit_o(ram_hit_o)
);

// File: tb/tb_pgx_map_top.sv
`timescale 1ns/1ps
module tb_pgx_map_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cs, bus_rw, bus_vma;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  page_o;
  logic [19:0] phys_addr_o;
  logic        rom_hit_o, io_hit_o, ram_hit_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  pgx_map_top dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rw(bus_rw),
    .bus_vma(bus_vma), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .page_o(page_o), .phys_addr_o(phys_addr_o),
    .rom_hit_o(rom_hit_o), .io_hit_o(io_hit_o), .ram_hit_o(ram_hit_o)
  );

  function automatic logic [7:0] exp_page(input logic [3:0] idx);
    return {model[idx][7:4], ~model[idx][3:0]};
  endfunction

  function automatic logic [2:0] exp_region(input logic [15:0] a);
    logic [7:0] p;
    logic w;
    p = exp_page(a[15:12]);
    w = (a[15:8] == 8'hFF);
    return {w | (p[3:0] == 4'hF), ~w & (p[3:0] == 4'hE), ~w & (p[7:1] == 7'b0000110)};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s addr=%h got=%h exp=%h", req, bus_addr, got, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " R1 R2 page"}, 32'(page_o), 32'(exp_page(bus_addr[15:12])));
    chk({req, " R1 phys"}, 32'(phys_addr_o), 32'({exp_page(bus_addr[15:12]), bus_addr[11:0]}));
    chk({req, " R7 R8 R9 R10 region"}, 32'({rom_hit_o, io_hit_o, ram_hit_o}),
        32'(exp_region(bus_addr)));
  endtask

  // one bus cycle: drive at negedge, check before the edge, update model at the edge
  task automatic cyc(input logic cs, input logic vma, input logic rw,
                     input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    bus_cs = cs; bus_vma = vma; bus_rw = rw; bus_addr = a; bus_wdata = d;
    #1;
    check_outputs(req);
    @(posedge clk);
    if (cs && vma && !rw && a[15:8] == 8'hFF) model[a[3:0]] = d;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    bus_cs = 0; bus_vma = 0; bus_rw = 1; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst_n = 0;
    repeat (3) @(posedge clk);
    // R5: reset state on every page, while reset is still asserted
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bus_addr = {4'(i), 12'h123};
      #1;
      chk("R5 reset page", 32'(page_o), 32'h0F);
      chk("R5 R7 reset rom", 32'(rom_hit_o), 32'h1);
    end
    @(negedge clk);
    rst_n = 1;

    // R3: write all sixteen indices from window, read through every page
    for (int i = 0; i < 16; i++)
      cyc(1, 1, 0, {8'hFF, 4'(15 - i), 4'(i)}, 8'(8'h35 + i * 8'h17), "R3 R6 write");
    for (int i = 0; i < 16; i++)
      cyc(1, 1, 1, {4'(i), 12'hABC}, 8'h00, "R1 R3 readback");

    // R4: blocked writes leave the register unchanged
    cyc(0, 1, 0, 16'hFF05, 8'hAA, "R4 cs low");
    cyc(1, 0, 0, 16'hFF05, 8'hAA, "R4 vma low");
    cyc(1, 1, 1, 16'hFF05, 8'hAA, "R4 read");
    cyc(1, 1, 0, 16'hFE05, 8'hAA, "R4 outside window");
    cyc(1, 1, 1, 16'h5000, 8'h00, "R4 page5 unchanged");

    // R8 R9: region codes (out low nibble = ~stored)
    cyc(1, 1, 0, 16'hFF02, 8'h21, "R8 write");
    cyc(1, 1, 1, 16'h2345, 8'h00, "R8 io page");
    cyc(1, 1, 0, 16'hFF03, 8'h03, "R9 write 0C");
    cyc(1, 1, 1, 16'h3456, 8'h00, "R9 ram 0C");
    cyc(1, 1, 0, 16'hFF03, 8'h02, "R9 write 0D");
    cyc(1, 1, 1, 16'h3FFF, 8'h00, "R9 ram 0D");
    cyc(1, 1, 0, 16'hFF04, 8'h12, "R9 near miss write");
    cyc(1, 1, 1, 16'h4000, 8'h00, "R9 near miss 1D");

    // R6: write the page being translated (page F from FF0F)
    cyc(1, 1, 0, 16'hFF0F, 8'h5A, "R6 self write");
    cyc(1, 1, 1, 16'hF100, 8'h00, "R6 self next");
    cyc(1, 1, 0, 16'hFF0F, 8'hC3, "R6 self again");
    cyc(1, 1, 1, 16'hFF80, 8'h00, "R6 R7 window read");

    // random traffic aimed partly at the write window
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(9) < 4) a[15:8] = 8'hFF;
      cyc($urandom_range(9) < 8, $urandom_range(9) < 9, $urandom_range(1) == 1,
          a, 8'($urandom), "R1 R4 R6 random");
    end

    // R5: reset again clears everything
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++)
      cyc(0, 0, 1, {4'(i), 12'h000}, 8'h00, "R5 reset again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule